// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every data beat of a memory burst. A mode write loads a burst length code and an ordering bit. A start pulse then supplies an 8-bit starting column and a direction, read or write. From that point the block puts out one column address per clock, each marked by a valid strobe, until the burst completes. Finite bursts hold 2, 4 or 8 beats. A full-page burst steps through all 256 columns and keeps running until a stop request arrives.

The ordering bit chooses one of two patterns. Sequential ordering counts upward inside the aligned block the burst belongs to. Interleaved ordering XORs the beat number into the low address bits. A write burst starts at once. A read burst waits for the fixed read latency before its first address appears. The block refuses two illegal cases: a full page combined with interleaved ordering, and a full page that starts on an odd column. A one-cycle done pulse follows the final beat of every burst that ends normally or by stop.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held and just after it, col_valid, done and start_err are 0. The mode register holds length code 0 with sequential ordering, so mode_err is 0.
- R2: Length codes are 0 for 2 beats, 1 for 4 beats, 2 for 8 beats and 3 for a full page. With mode_ilv = 0, beat n of a finite burst has address (start & ~(BL-1)) | ((start + n) & (BL-1)). The low bits wrap inside the aligned block and the upper bits stay as they were.
- R3: With mode_ilv = 1, beat n of a finite burst has address start ^ (n & (BL-1)).
- R4: A sequential full-page burst steps up by one each beat, wraps from 255 to 0, and keeps going until stop is sampled high.
- R5: mode_err is 1 exactly when the mode register holds length code 3 together with mode_ilv = 1. A start seen while mode_err is 1 is refused: start_err pulses high in the cycle after it, and no beat follows.
- R6: When length code 3 is sequential, a start with an odd start_col (bit 0 = 1) is refused the same way: start_err pulses and no beat follows.
- R7: For a write start (start_rd = 0), beat 0 is valid in the cycle right after the edge that samples start. For a read start (start_rd = 1), col_valid stays 0 for three cycles, and beat 0 is valid after the third edge following the start edge.
- R8: done is a one-cycle pulse in the cycle right after the last valid beat. col_valid is 0 in that cycle.
- R9: A start during a burst cancels it with no done pulse. The new burst begins on its own schedule.
- R10: Stop ends a running burst: the beat visible when stop is sampled is the last one, and done follows. Stop while the block is idle has no effect.
- R11: A burst keeps the length and ordering that were in force when it started. A mode write during the burst affects only later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Loads mode_len and mode_ilv into the mode register |
| mode_len | input | 2 | Burst length code: 0=2, 1=4, 2=8, 3=full page |
| mode_ilv | input | 1 | 1 selects interleaved ordering, 0 selects sequential |
| start | input | 1 | Starts a burst at start_col |
| start_rd | input | 1 | 1 for a read burst (delayed by the read latency), 0 for a write burst |
| start_col | input | 8 | Starting column |
| stop | input | 1 | Terminates the running burst |
| col_out | output | 8 | Column address of the current beat |
| col_valid | output | 1 | col_out holds a beat |
| done | output | 1 | One-cycle pulse after the last beat |
| mode_err | output | 1 | The programmed mode is illegal |
| start_err | output | 1 | The previous start was refused |

## Verification
A write burst puts beat 0 on the outputs right after the edge that samples start. Beat n follows n edges later, and done appears one edge after the last beat. A read burst shifts this whole schedule three edges later. start_err appears one edge after the start that was refused. The bench drives its inputs at the falling edge and samples at the following falling edge. From the start edge it counts exactly the number of edges that the requirement gives before it compares col_out, col_valid and done. The expected address of each beat comes from the requirement formulas.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W  = 8,
  parameter int RD_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [1:0]       mode_len,
  input  logic             mode_ilv,
  input  logic             start,
  input  logic             start_rd,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             done,
  output logic             mode_err,
  output logic             start_err
);

  localparam int         LAT_W    = $clog2(RD_LAT + 1);
  localparam logic [1:0] LEN_FULL = 2'd3;

  logic [1:0]       len_m, len_q;
  logic             ilv_m, ilv_q;
  logic [COL_W-1:0] base_q, beat_q, mask;
  logic [LAT_W-1:0] wait_q;
  logic             active_q, done_q, serr_q;
  logic             bad_start, last_beat;

  always_comb begin
    case (len_q)
      2'd0:    mask = COL_W'(1);
      2'd1:    mask = COL_W'(3);
      2'd2:    mask = COL_W'(7);
      default: mask = '1;
    endcase
  end

  assign mode_err  = (len_m == LEN_FULL) && ilv_m;
  assign bad_start = mode_err || ((len_m == LEN_FULL) && start_col[0]);
  assign last_beat = (len_q != LEN_FULL) && (beat_q == mask);

  assign col_out   = ilv_q ? (base_q ^ (beat_q & mask))
                           : ((base_q & ~mask) | ((base_q + beat_q) & mask));
  assign col_valid = active_q;
  assign done      = done_q;
  assign start_err = serr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_m    <= 2'd0;
      ilv_m    <= 1'b0;
      len_q    <= 2'd0;
      ilv_q    <= 1'b0;
      base_q   <= '0;
      beat_q   <= '0;
      wait_q   <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      serr_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      serr_q <= 1'b0;
      if (mode_wr) begin
        len_m <= mode_len;
        ilv_m <= mode_ilv;
      end
      if (start) begin
        serr_q <= bad_start;
        len_q  <= len_m;
        ilv_q  <= ilv_m;
        base_q <= start_col;
        beat_q <= '0;
        if (bad_start) begin
          active_q <= 1'b0;
          wait_q   <= '0;
        end else if (start_rd) begin
          active_q <= 1'b0;
          wait_q   <= LAT_W'(RD_LAT);
        end else begin
          active_q <= 1'b1;
          wait_q   <= '0;
        end
      end else if (wait_q != '0) begin
        if (stop) begin
          wait_q <= '0;
        end else if (wait_q == LAT_W'(1)) begin
          wait_q   <= '0;
          active_q <= 1'b1;
        end else begin
          wait_q <= wait_q - LAT_W'(1);
        end
      end else if (active_q) begin
        if (stop || last_beat) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          beat_q <= beat_q + COL_W'(1);
        end
      end
    end
  end

  AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(col_valid)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_VALID_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({col_valid, done})); // R8
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode_err) |=> (start_err && !col_valid)); // R5
  AST_ODD_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && bad_start) |=> !col_valid); // R6
  AST_RD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_rd) |=> !col_valid); // R7
  AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && $past(col_valid) && !$past(start) && len_q == LEN_FULL && !ilv_q)
      |-> (col_out == $past(col_out) + COL_W'(1))); // R4

endmodule

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {rd, len[1:0], ilv, col[7:0]}
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 1'b0, 8'h13},
    {1'b0, 2'd1, 1'b0, 8'h25},
    {1'b0, 2'd1, 1'b1, 8'h25},
    {1'b0, 2'd2, 1'b0, 8'h5D},
    {1'b0, 2'd2, 1'b1, 8'h5D},
    {1'b1, 2'd1, 1'b0, 8'hA6},
    {1'b1, 2'd2, 1'b1, 8'hF3},
    {1'b1, 2'd0, 1'b1, 8'h80}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_wr = 1'b0, mode_ilv = 1'b0, start = 1'b0, start_rd = 1'b0, stop = 1'b0;
  logic [1:0] mode_len = 2'd0;
  logic [7:0] start_col = 8'h00;
  logic [7:0] col_out;
  logic col_valid, done, mode_err, start_err;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_gen i_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_len(mode_len),
    .mode_ilv(mode_ilv), .start(start), .start_rd(start_rd),
    .start_col(start_col), .stop(stop), .col_out(col_out),
    .col_valid(col_valid), .done(done), .mode_err(mode_err),
    .start_err(start_err));

  function automatic logic [7:0] exp_col(input int len, input bit ilv,
                                         input logic [7:0] c, input int n);
    int bl = (len == 3) ? 256 : (2 << len);
    logic [7:0] m = 8'(bl - 1);
    if (ilv) return c ^ (8'(n) & m);
    return (c & ~m) | ((c + 8'(n)) & m);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input int len, input bit ilv);
    mode_wr = 1'b1; mode_len = 2'(len); mode_ilv = ilv;
    @(posedge clk); @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic kick(input bit rd, input logic [7:0] col);
    start = 1'b1; start_rd = rd; start_col = col;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_burst(input bit rd, input int len, input bit ilv,
                           input logic [7:0] col, input string req);
    int bl = 2 << len;
    set_mode(len, ilv);
    kick(rd, col);
    if (rd) begin
      for (int i = 0; i < 3; i++) begin
        chk("R7 read wait valid", col_valid, 0);
        @(negedge clk);
      end
    end
    for (int n = 0; n < bl; n++) begin
      chk({req, " valid"}, col_valid, 1);
      chk({req, " col"}, col_out, exp_col(len, ilv, col, n));
      @(negedge clk);
    end
    chk("R8 done after last", done, 1);
    chk("R8 valid low at done", col_valid, 0);
    @(negedge clk);
    chk("R8 done single pulse", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", col_valid, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset start_err", start_err, 0);
    chk("R1 reset mode_err", mode_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset valid", col_valid, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [11:0] e = VEC[v];
      run_burst(e[11], int'(e[10:9]), e[8], e[7:0], e[8] ? "R3 interleaved" : "R2 sequential");
    end

    // R4 / R10: full page, wrap and stop
    set_mode(3, 1'b0);
    chk("R5 legal full mode_err", mode_err, 0);
    kick(1'b0, 8'hFC);
    for (int n = 0; n < 6; n++) begin
      chk("R4 full valid", col_valid, 1);
      chk("R4 full col wrap", col_out, (8'hFC + n) & 8'hFF);
      if (n == 5) stop = 1'b1;
      @(negedge clk);
    end
    stop = 1'b0;
    chk("R10 stop done", done, 1);
    chk("R10 stop valid low", col_valid, 0);
    stop = 1'b1;
    @(posedge clk); @(negedge clk);
    stop = 1'b0;
    chk("R10 idle stop no done", done, 0);
    chk("R10 idle stop no valid", col_valid, 0);

    // R6: odd start in full page
    kick(1'b0, 8'h31);
    chk("R6 odd start_err", start_err, 1);
    chk("R6 odd no valid", col_valid, 0);
    @(negedge clk);
    chk("R6 odd still idle", col_valid, 0);

    // R5: full page with interleaving
    set_mode(3, 1'b1);
    chk("R5 mode_err set", mode_err, 1);
    kick(1'b0, 8'h40);
    chk("R5 start_err", start_err, 1);
    chk("R5 no valid", col_valid, 0);
    @(negedge clk);
    chk("R5 start_err pulse", start_err, 0);

    // R9: a new start cancels the running burst
    set_mode(2, 1'b0);
    chk("R5 mode_err cleared", mode_err, 0);
    kick(1'b0, 8'h10);
    @(negedge clk);
    chk("R9 first burst beat1", col_out, 8'h11);
    set_mode(0, 1'b0);
    kick(1'b0, 8'h45);
    chk("R9 no done on cancel", done, 0);
    chk("R9 new burst beat0", col_out, 8'h45);
    @(negedge clk);
    chk("R9 new burst beat1", col_out, 8'h44);
    @(negedge clk);
    chk("R9 done after new burst", done, 1);

    // R11: mode write mid-burst keeps the captured mode
    set_mode(1, 1'b0);
    kick(1'b0, 8'h0A);
    chk("R11 beat0", col_out, 8'h0A);
    set_mode(0, 1'b1);
    chk("R11 beat1", col_out, 8'h0B);
    @(negedge clk);
    chk("R11 beat2", col_out, 8'h08);
    @(negedge clk);
    chk("R11 beat3", col_out, 8'h09);
    @(negedge clk);
    chk("R11 done", done, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule